// File: doc/BRIEF.md
# Keyed Lock and Commit Gate

This block keeps a small peripheral configuration register from being changed by stray software writes. It has two levels of protection. A lock bit clears only when software writes one fixed 32-bit key to the lock word. While the lock bit is clear, software may load an 8-bit commit mask. Every write to the protected function-select register then changes only the bit positions that the mask enables. All other bits keep their stored value.

Software reaches the block through one write/read port: a word address, write data and a write strobe. A registered read-data bus returns the stored value of the addressed word one clock after the address is presented. The protected register also drives the `sel_o` output continuously, so downstream pad logic always sees the current selection.

The lock is a two-state machine. `LK_SEALED` is entered at reset and on the transition KEY_MISS (a lock-word write carrying any value other than the key). `LK_OPEN` is entered on the transition KEY_MATCH (a lock-word write carrying exactly the key). In every other cycle the state holds (transition HOLD).

Top module: `keyed_commit_gate`

## Requirements
- R1: After reset the block is locked, the commit mask is 8'hFF, the function-select register and `sel_o` are 8'h00, and `rdata` is 0.
- R2: A write of exactly 32'h0ACCE551 to word 0 (lock) unlocks the block, and a read of word 0 then returns 0.
- R3: A write of any other value to word 0 locks the block, including values that differ from the key by one bit, and a read of word 0 then returns 1.
- R4: A read of word 0 returns the lock state in bit 0 (1 = locked, 0 = unlocked), with bits 31:1 zero.
- R5: While the block is locked, a write to word 1 (commit mask) is ignored, and the mask read back from word 1 keeps its previous value.
- R6: While the block is unlocked, a write to word 1 stores wdata[7:0]. The upper data bits are discarded, and word 1 reads back as zero-extended.
- R7: A write to word 2 (function select) changes only the bit positions set in the commit mask. This holds whether the block is locked or not. The other bits keep their value.
- R8: A change in lock state applies to the write in the very next cycle. A key write followed directly by a commit write has the commit write accepted.
- R9: `rdata` is registered. In the cycle after the address is presented, it shows the value stored before that clock edge, so a write and a read of the same word in the same cycle return the old value. Word 3 reads 0, and writes to word 3 change nothing.
- R10: `sel_o` always equals the stored function-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word address: 0 lock, 1 commit mask, 2 function select, 3 unused |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| sel_o | output | 8 | Current protected function-select value |

## Verification
Two functions can fall in the same cycle, and the bench provokes both cases. The first is a write of the lock word that is also the word being read. The bench presents the relock write with the address on word 0 and expects the unlocked value (0) on `rdata` one cycle later. It expects the locked value (1) the cycle after that. The second case puts the state change and its first use on adjacent cycles: key, commit and select writes are driven back to back, and `sel_o` must show the newly committed bits after the select write.

// File: rtl/kcg_pkg.sv
package kcg_pkg;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] WA_LOCK   = 2'd0;
    localparam logic [ADDR_W-1:0] WA_COMMIT = 2'd1;
    localparam logic [ADDR_W-1:0] WA_SEL    = 2'd2;
    localparam logic [ADDR_W-1:0] WA_SPARE  = 2'd3;

    typedef enum logic {
        LK_SEALED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

endpackage

// File: rtl/kcg_lock_fsm.sv
module kcg_lock_fsm #(
    parameter int unsigned       DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY    = 32'h0ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              locked
);
    import kcg_pkg::*;

    lock_state_e state_q;
    lock_state_e state_d;
    logic        key_hit;

    assign key_hit = (key_val == KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_SEALED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: KEY_MATCH, KEY_MISS, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SEALED: begin
                if (key_wr && key_hit) begin
                    state_d = LK_OPEN;
                end
            end
            LK_OPEN: begin
                if (key_wr && !key_hit) begin
                    state_d = LK_SEALED;
                end
            end
            default: state_d = LK_SEALED;
        endcase
    end

    always_comb begin
        locked = (state_q == LK_SEALED);
    end

endmodule

// File: rtl/kcg_commit_reg.sv
module kcg_commit_reg #(
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_wr,
    input  logic             locked,
    input  logic [CFG_W-1:0] wval,
    output logic [CFG_W-1:0] mask
);
    logic [CFG_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (commit_wr && !locked) begin
            mask_q <= wval;
        end
    end

    assign mask = mask_q;

endmodule

// File: rtl/kcg_masked_reg.sv
module kcg_masked_reg #(
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [CFG_W-1:0] enable_bits,
    input  logic [CFG_W-1:0] wval,
    output logic [CFG_W-1:0] value
);
    logic [CFG_W-1:0] bits_q;

    for (genvar b = 0; b < CFG_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[b] <= 1'b0;
            end else if (sel_wr && enable_bits[b]) begin
                bits_q[b] <= wval[b];
            end
        end
    end

    assign value = bits_q;

endmodule

// File: rtl/kcg_readback.sv
module kcg_readback #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CFG_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [kcg_pkg::ADDR_W-1:0] raddr,
    input  logic                       locked,
    input  logic [CFG_W-1:0]           mask,
    input  logic [CFG_W-1:0]           sel,
    output logic [DATA_W-1:0]          rdata
);
    import kcg_pkg::*;

    localparam int unsigned PAD_W = DATA_W - CFG_W;

    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rd_q;

    always_comb begin
        rd_d = '0;
        unique case (raddr)
            WA_LOCK:   rd_d = {{(DATA_W-1){1'b0}}, locked};
            WA_COMMIT: rd_d = {{PAD_W{1'b0}}, mask};
            WA_SEL:    rd_d = {{PAD_W{1'b0}}, sel};
            WA_SPARE:  rd_d = '0;
            default:   rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/keyed_commit_gate.sv
module keyed_commit_gate #(
    parameter int unsigned       DATA_W = 32,
    parameter int unsigned       CFG_W  = 8,
    parameter logic [DATA_W-1:0] KEY    = 32'h0ACCE551
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [kcg_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       wr_en,
    output logic [DATA_W-1:0]          rdata,
    output logic [CFG_W-1:0]           sel_o
);
    import kcg_pkg::*;

    logic             locked_q;
    logic [CFG_W-1:0] mask_q;
    logic [CFG_W-1:0] sel_q;
    logic             wr_lock;
    logic             wr_commit;
    logic             wr_sel;

    assign wr_lock   = wr_en && (addr == WA_LOCK);
    assign wr_commit = wr_en && (addr == WA_COMMIT);
    assign wr_sel    = wr_en && (addr == WA_SEL);

    kcg_lock_fsm #(
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (wr_lock),
        .key_val (wdata),
        .locked  (locked_q)
    );

    kcg_commit_reg #(
        .CFG_W (CFG_W)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_wr (wr_commit),
        .locked    (locked_q),
        .wval      (wdata[CFG_W-1:0]),
        .mask      (mask_q)
    );

    kcg_masked_reg #(
        .CFG_W (CFG_W)
    ) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr      (wr_sel),
        .enable_bits (mask_q),
        .wval        (wdata[CFG_W-1:0]),
        .value       (sel_q)
    );

    kcg_readback #(
        .DATA_W (DATA_W),
        .CFG_W  (CFG_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .raddr  (addr),
        .locked (locked_q),
        .mask   (mask_q),
        .sel    (sel_q),
        .rdata  (rdata)
    );

    assign sel_o = sel_q;

endmodule

// File: rtl/kcg_checker.sv
module kcg_checker #(
    parameter int unsigned       DATA_W = 32,
    parameter int unsigned       CFG_W  = 8,
    parameter logic [DATA_W-1:0] KEY    = 32'h0ACCE551
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [kcg_pkg::ADDR_W-1:0] addr,
    input logic [DATA_W-1:0]          wdata,
    input logic                       wr_en,
    input logic [DATA_W-1:0]          rdata,
    input logic [CFG_W-1:0]           sel_o,
    input logic                       locked_q,
    input logic [CFG_W-1:0]           mask_q
);
    import kcg_pkg::*;

    // R2
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == WA_LOCK && wdata == KEY) |=> !locked_q);

    // R3
    bad_key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == WA_LOCK && wdata != KEY) |=> locked_q);

    // R5
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mask_q));

    // R7
    sel_outside_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == WA_SEL) |=> ((sel_o ^ $past(sel_o)) & ~$past(mask_q)) == '0);

    // R9
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == WA_SEL) |=> $stable(sel_o));

    // R4
    lock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == WA_LOCK) |=> rdata == {{(DATA_W-1){1'b0}}, $past(locked_q)});

endmodule

bind keyed_commit_gate kcg_checker #(
    .DATA_W (DATA_W),
    .CFG_W  (CFG_W),
    .KEY    (KEY)
) u_kcg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rdata    (rdata),
    .sel_o    (sel_o),
    .locked_q (locked_q),
    .mask_q   (mask_q)
);

// File: tb/keyed_commit_gate_bench.sv
module keyed_commit_gate_bench;

    localparam int VW = 69;
    localparam int NV = 14;

    // {we, waddr, wdata, raddr, expected read}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 2'd2, 32'h0000005A, 2'd2, 32'h0000005A}, // R7 full mask while locked
        {1'b1, 2'd1, 32'h0000000F, 2'd1, 32'h000000FF}, // R5 locked commit ignored
        {1'b1, 2'd0, 32'h0ACCE550, 2'd0, 32'h00000001}, // R3 near key
        {1'b1, 2'd0, 32'h0ACCE551, 2'd0, 32'h00000000}, // R2 R4 key
        {1'b1, 2'd1, 32'hFFFFFF0F, 2'd1, 32'h0000000F}, // R6 low byte only
        {1'b1, 2'd2, 32'h000000A5, 2'd2, 32'h00000055}, // R7 partial mask
        {1'b1, 2'd0, 32'h00000000, 2'd0, 32'h00000001}, // R3 relock
        {1'b1, 2'd1, 32'h00000000, 2'd1, 32'h0000000F}, // R5
        {1'b1, 2'd2, 32'h000000FF, 2'd2, 32'h0000005F}, // R7 locked, mask kept
        {1'b1, 2'd0, 32'h0ACCE551, 2'd0, 32'h00000000}, // R2
        {1'b1, 2'd1, 32'h00000000, 2'd1, 32'h00000000}, // R6 empty mask
        {1'b1, 2'd2, 32'h00000000, 2'd2, 32'h0000005F}, // R7 nothing enabled
        {1'b1, 2'd3, 32'hFFFFFFFF, 2'd3, 32'h00000000}, // R9 spare word
        {1'b1, 2'd0, 32'h1ACCE551, 2'd0, 32'h00000001}  // R3 upper bit differs
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  sel_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    keyed_commit_gate u_keyed_commit_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rdata (rdata),
        .sel_o (sel_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", rdata, 32'h0);
        chk("R1 sel_o in reset", {24'h0, sel_o}, 32'h0);
        rst_n = 1'b1;
        addr = 2'd0;
        @(negedge clk);
        chk("R1 locked after reset", rdata, 32'h1);
        addr = 2'd1;
        @(negedge clk);
        chk("R1 mask after reset", rdata, 32'hFF);

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i][68];
            addr  = VEC[i][67:66];
            wdata = VEC[i][65:34];
            @(negedge clk);
            wr_en = 1'b0;
            addr  = VEC[i][33:32];
            @(negedge clk);
            chk($sformatf("vector %0d", i), rdata, VEC[i][31:0]);
        end
        chk("R10 sel_o tracks register", {24'h0, sel_o}, 32'h5F);

        // R8: key, commit, select on consecutive cycles
        wr_en = 1'b1;
        addr = 2'd0; wdata = 32'h0ACCE551;
        @(negedge clk);
        addr = 2'd1; wdata = 32'h0000003C;
        @(negedge clk);
        addr = 2'd2; wdata = 32'h000000FF;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 back-to-back commit used", {24'h0, sel_o}, 32'h7F);

        // R9: relock write and lock read in the same cycle
        wr_en = 1'b1; addr = 2'd0; wdata = 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 same-cycle read shows old lock", rdata, 32'h0);
        @(negedge clk);
        chk("R9 next read shows new lock", rdata, 32'h1);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 sel_o cleared by reset", {24'h0, sel_o}, 32'h0);
        rst_n = 1'b1; addr = 2'd1;
        @(negedge clk);
        chk("R1 mask restored", rdata, 32'hFF);
        addr = 2'd2;
        @(negedge clk);
        chk("R1 select cleared", rdata, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule